// File: doc/BRIEF.md
# Operand Barrel Shifter

This block produces the second operand of a data-processing datapath, together with the carry-out that a flag-setting operation would use. It takes the operand in one of three forms. The first is an 8-bit constant rotated right by an even amount. The second is a register value shifted by a 5-bit constant amount. The third is a register value shifted by an amount taken from the low byte of a second register. A fourth form passes the register value through unshifted. The shift kind is a 2-bit code. Whenever no shift actually happens, the carry-out is the incoming C flag.

Register-file reads and the ALU are outside the block. When the register-amount form reads the program counter as its value register or as its amount register, the caller says so on a flag input, and the block adds 4 to that read. A result is registered one cycle after `valid_i` is sampled. The outputs then hold until the next valid request.

Top module: `opsh_top`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `result_o` and `carry_o` are all 0.
- R2: `valid_o` follows `valid_i` with one cycle of latency. After a cycle with `valid_i` low, `result_o` and `carry_o` keep their previous values.
- R3: With `form_i`=0 (immediate), the zero-extended `imm_i` is rotated right by 2×`rot_i`. For a nonzero `rot_i`, the carry is bit 31 of the result. For `rot_i`=0, the value is unchanged and the carry is `c_i`.
- R4: `type_i` encodes 0=LSL, 1=LSR, 2=ASR and 3=ROR. With `form_i`=1 (constant amount) and a nonzero `shamt_i`, `rm_i` is shifted by `shamt_i`. The carry is the last bit shifted out, or bit 31 of the result for ROR.
- R5: With `form_i`=1 and `shamt_i`=0, LSL leaves the value unchanged with carry `c_i`. LSR gives 0 with carry = bit 31. ASR fills every bit with bit 31 and sets carry = bit 31.
- R6: With `form_i`=1, ROR and `shamt_i`=0, the result is {`c_i`, `rm_i`[31:1]} and the carry is `rm_i`[0].
- R7: With `form_i`=2 (register amount), only the 8-bit `rs_byte_i` sets the amount. An amount of 0 leaves the value unchanged with carry `c_i`, for every shift type.
- R8: With `form_i`=2, an LSL by 32 gives 0 with carry = bit 0. An LSR by 32 gives 0 with carry = bit 31. LSL or LSR by more than 32 gives 0 with carry 0.
- R9: With `form_i`=2, an ASR by 32 or more fills every bit with bit 31 and sets carry = bit 31.
- R10: With `form_i`=2 and ROR by a nonzero amount, the value rotates by the amount mod 32 and the carry is bit 31 of the result. A nonzero multiple of 32 returns the value unchanged, with carry = bit 31.
- R11: With `form_i`=2, `rm_is_pc_i` adds 4 to the shifted value, and `rs_is_pc_i` adds 4 to the amount byte (mod 256). In the other forms both flags are ignored.
- R12: With `form_i`=3 (pass), the result is `rm_i` unchanged and the carry is `c_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| form_i | input | 2 | Operand form: 0 immediate, 1 constant amount, 2 register amount, 3 pass |
| type_i | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_i | input | 8 | Immediate constant |
| rot_i | input | 4 | Immediate rotate field (rotation = 2×value) |
| shamt_i | input | 5 | Constant shift amount |
| rm_i | input | 32 | Value register read |
| rm_is_pc_i | input | 1 | Value register is the program counter |
| rs_byte_i | input | 8 | Low byte of the amount register |
| rs_is_pc_i | input | 1 | Amount register is the program counter |
| c_i | input | 1 | Current C flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The in-RTL properties check the following on every request: the unrotated immediate, the LSR-by-zero reinterpretation, the zero and saturated cases of the register-amount form, the pass form, and output hold on idle cycles. Only the bench scenarios can show the following:
- the nonzero shifts and their carries;
- RRX;
- rotate amounts reduced mod 32;
- the +4 read adjustment, including the wrap of the amount byte past 255.

These cases are compared against a bit-at-a-time reference model.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_type_e;

  typedef enum logic [1:0] {
    FORM_IMM     = 2'd0,
    FORM_REG_IMM = 2'd1,
    FORM_REG_REG = 2'd2,
    FORM_PASS    = 2'd3
  } form_e;

  typedef enum logic [2:0] {
    K_LSL,
    K_LSR,
    K_ASR,
    K_ROR,
    K_RRX
  } kind_e;
endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int RSAMT_W = 8,
  parameter int SHAMT_W = $clog2(DATA_W),
  parameter int AMT_W   = $clog2(DATA_W) + 2
) (
  input  logic [1:0]         form_i,
  input  logic [1:0]         type_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [ROT_W-1:0]   rot_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  rm_i,
  input  logic               rm_is_pc_i,
  input  logic [RSAMT_W-1:0] rs_byte_i,
  input  logic               rs_is_pc_i,
  output logic [DATA_W-1:0]  operand_o,
  output kind_e              kind_o,
  output logic [AMT_W-1:0]   amt_o
);
  localparam logic [RSAMT_W-1:0] LIM_LOG = RSAMT_W'(DATA_W + 1);
  localparam logic [RSAMT_W-1:0] LIM_ASR = RSAMT_W'(DATA_W);
  localparam logic [AMT_W-1:0]   AMT_FULL = AMT_W'(DATA_W);

  logic [DATA_W-1:0]  rm_adj;
  logic [RSAMT_W-1:0] rs_amt;
  sh_type_e           sh_type;
  form_e              form;

  assign sh_type = sh_type_e'(type_i);
  assign form    = form_e'(form_i);
  // PC reads ahead by one word in the register-amount form only
  assign rm_adj  = rm_i + ((form == FORM_REG_REG && rm_is_pc_i) ? DATA_W'(4) : '0);
  assign rs_amt  = rs_byte_i + ((form == FORM_REG_REG && rs_is_pc_i) ? RSAMT_W'(4) : '0);

  always_comb begin
    operand_o = rm_i;
    kind_o    = K_LSL;
    amt_o     = '0;
    unique case (form)
      FORM_IMM: begin
        operand_o = DATA_W'(imm_i);
        kind_o    = K_ROR;
        amt_o     = AMT_W'({rot_i, 1'b0});
      end
      FORM_REG_IMM: begin
        unique case (sh_type)
          SH_LSL: begin kind_o = K_LSL; amt_o = AMT_W'(shamt_i); end
          SH_LSR: begin kind_o = K_LSR; amt_o = (shamt_i == '0) ? AMT_FULL : AMT_W'(shamt_i); end
          SH_ASR: begin kind_o = K_ASR; amt_o = (shamt_i == '0) ? AMT_FULL : AMT_W'(shamt_i); end
          SH_ROR: begin
            kind_o = (shamt_i == '0) ? K_RRX : K_ROR;
            amt_o  = (shamt_i == '0) ? AMT_W'(1) : AMT_W'(shamt_i);
          end
        endcase
      end
      FORM_REG_REG: begin
        operand_o = rm_adj;
        unique case (sh_type)
          SH_LSL: begin kind_o = K_LSL; amt_o = AMT_W'((rs_amt > LIM_LOG) ? LIM_LOG : rs_amt); end
          SH_LSR: begin kind_o = K_LSR; amt_o = AMT_W'((rs_amt > LIM_LOG) ? LIM_LOG : rs_amt); end
          SH_ASR: begin kind_o = K_ASR; amt_o = AMT_W'((rs_amt > LIM_ASR) ? LIM_ASR : rs_amt); end
          SH_ROR: begin
            kind_o = K_ROR;
            if (rs_amt == '0)                       amt_o = '0;
            else if (rs_amt[SHAMT_W-1:0] == '0)     amt_o = AMT_FULL;
            else                                    amt_o = AMT_W'(rs_amt[SHAMT_W-1:0]);
          end
        endcase
      end
      FORM_PASS: begin
        operand_o = rm_i;
        kind_o    = K_LSL;
        amt_o     = '0;
      end
    endcase
  end
endmodule

// File: rtl/opsh_shift.sv
module opsh_shift
  import opsh_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W),
  parameter int AMT_W   = $clog2(DATA_W) + 2
) (
  input  logic [DATA_W-1:0] operand_i,
  input  kind_e             kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam logic [SHAMT_W:0] DW_C = (SHAMT_W+1)'(DATA_W);

  // one guard bit on the exit side catches the last bit shifted out
  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_w;
  logic [DATA_W-1:0]      rot_w;
  logic [SHAMT_W-1:0]     rot_s;

  assign rot_s = amt_i[SHAMT_W-1:0];
  assign lsl_w = {1'b0, operand_i} << amt_i;
  assign lsr_w = {operand_i, 1'b0} >> amt_i;
  assign asr_w = $signed({operand_i, 1'b0}) >>> amt_i;
  assign rot_w = (operand_i >> rot_s) | (operand_i << (DW_C - {1'b0, rot_s}));

  always_comb begin
    result_o = operand_i;
    carry_o  = c_i;
    if (amt_i != '0) begin
      unique case (kind_i)
        K_LSL: begin result_o = lsl_w[DATA_W-1:0]; carry_o = lsl_w[DATA_W]; end
        K_LSR: begin result_o = lsr_w[DATA_W:1];   carry_o = lsr_w[0];      end
        K_ASR: begin result_o = asr_w[DATA_W:1];   carry_o = asr_w[0];      end
        K_ROR: begin result_o = rot_w;             carry_o = rot_w[DATA_W-1]; end
        K_RRX: begin result_o = {c_i, operand_i[DATA_W-1:1]}; carry_o = operand_i[0]; end
        default: begin result_o = operand_i; carry_o = c_i; end
      endcase
    end
  end
endmodule

// File: rtl/opsh_top.sv
module opsh_top
  import opsh_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int RSAMT_W = 8,
  localparam int SHAMT_W = $clog2(DATA_W),
  localparam int AMT_W   = $clog2(DATA_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         form_i,
  input  logic [1:0]         type_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [ROT_W-1:0]   rot_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [DATA_W-1:0]  rm_i,
  input  logic               rm_is_pc_i,
  input  logic [RSAMT_W-1:0] rs_byte_i,
  input  logic               rs_is_pc_i,
  input  logic               c_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o
);
  logic [DATA_W-1:0] operand;
  kind_e             kind;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] sh_res;
  logic              sh_carry;

  opsh_decode #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .RSAMT_W(RSAMT_W),
    .SHAMT_W(SHAMT_W), .AMT_W(AMT_W)
  ) u_decode (
    .form_i(form_i), .type_i(type_i), .imm_i(imm_i), .rot_i(rot_i),
    .shamt_i(shamt_i), .rm_i(rm_i), .rm_is_pc_i(rm_is_pc_i),
    .rs_byte_i(rs_byte_i), .rs_is_pc_i(rs_is_pc_i),
    .operand_o(operand), .kind_o(kind), .amt_o(amt)
  );

  opsh_shift #(
    .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .AMT_W(AMT_W)
  ) u_shift (
    .operand_i(operand), .kind_i(kind), .amt_i(amt), .c_i(c_i),
    .result_o(sh_res), .carry_o(sh_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= sh_res;
        carry_o  <= sh_carry;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o));

  p_imm_norot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_IMM && rot_i == '0 |=>
      result_o == DATA_W'($past(imm_i)) && carry_o == $past(c_i));

  p_lsr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_REG_IMM && type_i == SH_LSR && shamt_i == '0 |=>
      result_o == '0 && carry_o == $past(rm_i[DATA_W-1]));

  p_reg_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_REG_REG && !rm_is_pc_i && !rs_is_pc_i && rs_byte_i == '0 |=>
      result_o == $past(rm_i) && carry_o == $past(c_i));

  p_log_big_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_REG_REG && !rs_is_pc_i && (type_i == SH_LSL || type_i == SH_LSR)
      && rs_byte_i > RSAMT_W'(DATA_W) |=> result_o == '0 && !carry_o);

  p_asr_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_REG_REG && !rm_is_pc_i && !rs_is_pc_i && type_i == SH_ASR
      && rs_byte_i >= RSAMT_W'(DATA_W) |=>
      result_o == {DATA_W{$past(rm_i[DATA_W-1])}} && carry_o == $past(rm_i[DATA_W-1]));

  p_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && form_i == FORM_PASS |=> result_o == $past(rm_i) && carry_o == $past(c_i));
endmodule

// File: tb/tb_opsh_top.sv
`timescale 1ns/1ps
module tb_opsh_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  form = '0, typ = '0;
  logic [7:0]  imm = '0;
  logic [3:0]  rot = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] rm = '0;
  logic        rm_pc = 1'b0, rs_pc = 1'b0, cin = 1'b0;
  logic [7:0]  rs_byte = '0;
  logic        valid_o, carry_o;
  logic [31:0] result_o;

  typedef struct {
    logic [31:0] res;
    logic        cy;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opsh_top dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .form_i(form), .type_i(typ),
    .imm_i(imm), .rot_i(rot), .shamt_i(shamt), .rm_i(rm), .rm_is_pc_i(rm_pc),
    .rs_byte_i(rs_byte), .rs_is_pc_i(rs_pc), .c_i(cin),
    .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o)
  );

  // bit-at-a-time reference: {carry, result}
  function automatic logic [32:0] step_shift(logic [1:0] t, logic [31:0] v, int n, logic c);
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic logic [32:0] model(logic [1:0] f, logic [1:0] t, logic [7:0] im,
      logic [3:0] ro, logic [4:0] sh, logic [31:0] r, logic rp, logic [7:0] rb,
      logic sp, logic c);
    logic [7:0] a;
    case (f)
      2'd0: return step_shift(2'd3, {24'd0, im}, 2 * int'(ro), c);
      2'd1: begin
        if (sh != 0 || t == 2'd0) return step_shift(t, r, int'(sh), c);
        if (t == 2'd3) return {r[0], c, r[31:1]};
        return step_shift(t, r, 32, c);
      end
      2'd2: begin
        a = rb + (sp ? 8'd4 : 8'd0);
        return step_shift(t, r + (rp ? 32'd4 : 32'd0), int'(a), c);
      end
      default: return {c, r};
    endcase
  endfunction

  task automatic report_summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(string tag, logic [31:0] ar, logic ac, logic [31:0] er, logic ec);
    checks++;
    if (ar !== er || ac !== ec) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b", tag, ar, ac, er, ec);
    end
  endtask

  task automatic drive(logic [1:0] f, logic [1:0] t, logic [7:0] im, logic [3:0] ro,
      logic [4:0] sh, logic [31:0] r, logic rp, logic [7:0] rb, logic sp, logic c, string tag);
    exp_t e;
    logic [32:0] m;
    @(negedge clk);
    form = f; typ = t; imm = im; rot = ro; shamt = sh; rm = r;
    rm_pc = rp; rs_byte = rb; rs_pc = sp; cin = c; valid = 1'b1;
    m = model(f, t, im, ro, sh, r, rp, rb, sp, c);
    e.res = m[31:0]; e.cy = m[32]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid = 1'b0;
      rm = $urandom; rs_byte = 8'($urandom); cin = 1'($urandom); form = 2'($urandom);
    end
  endtask

  // monitor: pops on each valid result, checks hold on idle cycles
  initial begin : monitor
    exp_t last;
    bit have_last = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (valid_o) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2: unexpected valid_o result=%h expected no result", result_o);
          end else begin
            last = q.pop_front();
            have_last = 1;
            check(last.tag, result_o, carry_o, last.res, last.cy);
          end
        end else if (have_last) begin
          check("R2 hold", result_o, carry_o, last.res, last.cy);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      report_summary();
    end
  end

  initial begin : stim
    #1;
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%b result=%h carry=%b expected 0 0 0", valid_o, result_o, carry_o);
    end
    #20 rst_n = 1'b1;
    idle(2);

    // R3 immediate rotate
    drive(0, 0, 8'hFF, 4'd4, 0, 0, 0, 0, 0, 0, "R3 rot8");
    drive(0, 0, 8'h3F, 4'd1, 0, 0, 0, 0, 0, 0, "R3 rot2");
    drive(0, 0, 8'h80, 4'd0, 0, 0, 0, 0, 0, 1, "R3 rot0");
    drive(0, 0, 8'h01, 4'd15, 0, 32'hFFFF, 1, 0, 1, 0, "R3 rot30 flags ignored R11");
    // R4 constant-amount shifts
    drive(1, 0, 0, 0, 5'd4, 32'hF0000001, 0, 0, 0, 0, "R4 lsl4");
    drive(1, 1, 0, 0, 5'd1, 32'h00000003, 0, 0, 0, 0, "R4 lsr1");
    drive(1, 2, 0, 0, 5'd4, 32'h80000010, 0, 0, 0, 1, "R4 asr4");
    drive(1, 3, 0, 0, 5'd8, 32'h12345678, 0, 0, 0, 1, "R4 ror8");
    // R5 / R6 zero constant amount
    drive(1, 0, 0, 0, 5'd0, 32'h0000AAAA, 0, 0, 0, 1, "R5 lsl0");
    drive(1, 1, 0, 0, 5'd0, 32'h80000000, 0, 0, 0, 0, "R5 lsr0");
    drive(1, 2, 0, 0, 5'd0, 32'h80000000, 0, 0, 0, 0, "R5 asr0 neg");
    drive(1, 2, 0, 0, 5'd0, 32'h00007FFF, 0, 0, 0, 1, "R5 asr0 pos");
    drive(1, 3, 0, 0, 5'd0, 32'h00000003, 0, 0, 0, 1, "R6 rrx c1");
    drive(1, 3, 0, 0, 5'd0, 32'h80000002, 1, 0, 1, 0, "R6 rrx c0 flags ignored");
    idle(3);
    // R7 register amount zero
    for (int t = 0; t < 4; t++)
      drive(2, 2'(t), 0, 0, 5'd9, 32'hC3C3C3C3, 0, 8'd0, 0, 1'(t), "R7 amt0");
    // R8 logical saturations
    drive(2, 0, 0, 0, 0, 32'h00000001, 0, 8'd32, 0, 0, "R8 lsl32");
    drive(2, 0, 0, 0, 0, 32'hFFFFFFFF, 0, 8'd33, 0, 1, "R8 lsl33");
    drive(2, 0, 0, 0, 0, 32'hFFFFFFFF, 0, 8'd200, 0, 1, "R8 lsl200");
    drive(2, 1, 0, 0, 0, 32'h80000000, 0, 8'd32, 0, 0, "R8 lsr32");
    drive(2, 1, 0, 0, 0, 32'hFFFFFFFF, 0, 8'd40, 0, 1, "R8 lsr40");
    // R9 arithmetic saturation
    drive(2, 2, 0, 0, 0, 32'h80000001, 0, 8'd32, 0, 0, "R9 asr32 neg");
    drive(2, 2, 0, 0, 0, 32'h7FFFFFFF, 0, 8'd255, 0, 1, "R9 asr255 pos");
    // R10 register rotate
    drive(2, 3, 0, 0, 0, 32'h0000000F, 0, 8'd4, 0, 0, "R10 ror4");
    drive(2, 3, 0, 0, 0, 32'h0000000F, 0, 8'd36, 0, 0, "R10 ror36");
    drive(2, 3, 0, 0, 0, 32'h80000000, 0, 8'd32, 0, 0, "R10 ror32");
    drive(2, 3, 0, 0, 0, 32'h40000000, 0, 8'd64, 0, 1, "R10 ror64");
    // R11 PC adjustment
    drive(2, 0, 0, 0, 0, 32'h00000100, 1, 8'd0, 0, 0, "R11 rm pc");
    drive(2, 0, 0, 0, 0, 32'h00000101, 0, 8'd0, 1, 0, "R11 rs pc 4");
    drive(2, 1, 0, 0, 0, 32'h12345678, 0, 8'd252, 1, 1, "R11 rs pc wrap");
    drive(2, 3, 0, 0, 0, 32'hFFFFFFFC, 1, 8'd28, 1, 0, "R11 both pc");
    // R12 pass
    drive(3, 1, 8'h55, 4'd3, 5'd7, 32'hDEADBEEF, 1, 8'd9, 1, 1, "R12 pass");
    drive(3, 3, 8'h00, 4'd0, 5'd0, 32'h01234567, 0, 8'd1, 0, 0, "R12 pass c0");
    idle(2);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      f = 2'($urandom);
      drive(f, 2'($urandom), 8'($urandom), 4'($urandom), 5'($urandom), $urandom,
            1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            f == 0 ? "R3 mix" : f == 1 ? "R4 mix" : f == 2 ? "R8 mix" : "R12 mix");
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    done = 1;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d results missing, expected 0", q.size());
    end
    report_summary();
  end
endmodule